// File: doc/BRIEF.md
# CSR read-modify-write access unit

This block carries out the three register access operations of a processor's control and status registers: swap, set-bits and clear-bits. Each operation is reduced to one common masked write made of a new value and a write mask. A swap writes the source operand through an all-ones mask. A set-bits writes all ones through a mask equal to the source. A clear-bits writes zeros through that same mask. The masked write goes to a small local file of four registers, and the value the register held before the write is returned as the result.

A request is rejected, and the illegal-instruction flag raised in its place, when any of these holds: the address names no implemented register, the opcode is unused, the current privilege level is below the level that the address encodes, or the access would write a read-only register. When the source register field is zero, set-bits and clear-bits do not write at all. That makes them pure reads, which are legal even on a read-only register.

A request is presented for one cycle with `req_valid`. The response (`resp_valid`, `rdata`, `illegal`) appears on the following cycle, and the register update takes effect at that same clock edge.

Top module: `csr_rmw_unit`

## Requirements
- R1: Swap (op 2'b01) stores the source operand into the addressed register.
- R2: Set-bits (op 2'b10) with a nonzero source field stores old OR source.
- R3: Clear-bits (op 2'b11) with a nonzero source field stores old AND NOT source.
- R4: Set-bits or clear-bits with `src_nz`=0 leaves the register unchanged and returns its value, including on the read-only register.
- R5: Every request yields `resp_valid` exactly one cycle later, and a legal response's `rdata` is the register value from before the write.
- R6: An address other than 12'h040, 12'h140, 12'h340 and 12'hF11, or op 2'b00, gives `illegal`=1.
- R7: A request whose address bits [9:8] exceed `priv` (0 user, 1 supervisor, 3 machine) gives `illegal`=1.
- R8: Address bits [11:10]=2'b11 mark a read-only register. An access to it with a nonzero mask gives `illegal`=1, while set-bits with `src_nz`=1 and a zero source has a zero mask and stays legal.
- R9: A rejected request changes no register and returns `rdata`=0.
- R10: After reset the three writable registers read 0, register 12'hF11 reads RO_VALUE (default 32'h00000A5C), and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| op | input | 2 | 01 swap, 10 set-bits, 11 clear-bits, 00 unused |
| csr_addr | input | 12 | Register address |
| src | input | XLEN | Source operand |
| src_nz | input | 1 | Source register field is nonzero |
| priv | input | 2 | Current privilege level |
| resp_valid | output | 1 | Response strobe |
| rdata | output | XLEN | Old register value, 0 when rejected |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The assertions assume that `op`, `csr_addr`, `priv` and `src_nz` are stable and meaningful only while `req_valid` is high. They also assume that `priv` never takes the reserved value 2'b10. The bench drives each request for exactly one cycle, with inputs changed on the falling edge, and only ever uses privilege values 0, 1 and 3. Between requests it holds `req_valid` low so that each response stands alone.

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit #(
  parameter int          XLEN     = 32,
  parameter logic [11:0] A_USR    = 12'h040,
  parameter logic [11:0] A_SUP    = 12'h140,
  parameter logic [11:0] A_MCH    = 12'h340,
  parameter logic [11:0] A_RO     = 12'hF11,
  parameter logic [XLEN-1:0] RO_VALUE = 32'h0000_0A5C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      op,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] src,
  input  logic            src_nz,
  input  logic [1:0]      priv,
  output logic            resp_valid,
  output logic [XLEN-1:0] rdata,
  output logic            illegal
);
  localparam int NREG = 4;
  localparam logic [1:0] OP_SWAP = 2'b01;
  localparam logic [1:0] OP_SET  = 2'b10;
  localparam logic [1:0] OP_CLR  = 2'b11;

  logic [XLEN-1:0] file_q [NREG];
  logic [1:0]      idx;
  logic            hit;
  logic [XLEN-1:0] mask, nval, old;
  logic            deny, wr;

  always_comb begin
    hit = 1'b1;
    idx = 2'd0;
    case (csr_addr)
      A_USR:   idx = 2'd0;
      A_SUP:   idx = 2'd1;
      A_MCH:   idx = 2'd2;
      A_RO:    idx = 2'd3;
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    mask = '0;
    nval = '0;
    case (op)
      OP_SWAP: begin mask = '1; nval = src; end
      OP_SET:  begin mask = src_nz ? src : '0; nval = '1; end
      OP_CLR:  begin mask = src_nz ? src : '0; nval = '0; end
      default: ;
    endcase
  end

  assign old  = file_q[idx];
  assign deny = !hit || (op == 2'b00) || (csr_addr[9:8] > priv)
              || ((csr_addr[11:10] == 2'b11) && (|mask));
  assign wr   = req_valid && !deny && (|mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG - 1; i++) file_q[i] <= '0;
      file_q[NREG-1] <= RO_VALUE;
      resp_valid <= 1'b0;
      rdata      <= '0;
      illegal    <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      illegal    <= req_valid && deny;
      rdata      <= (req_valid && !deny) ? old : '0;
      for (int i = 0; i < NREG - 1; i++)
        if (wr && idx == 2'(i)) file_q[i] <= (old & ~mask) | (nval & mask);
    end
  end
endmodule

module csr_rmw_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      op,
  input logic [11:0]     csr_addr,
  input logic [XLEN-1:0] src,
  input logic            src_nz,
  input logic [1:0]      priv,
  input logic            resp_valid,
  input logic [XLEN-1:0] rdata,
  input logic            illegal
);
  p_resp_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  p_priv_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && csr_addr[9:8] > priv) |=> illegal);
  p_ro_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && csr_addr[11:10] == 2'b11 && op == 2'b01) |=> illegal);
  p_null_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == 2'b00) |=> illegal);
  p_reject_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (resp_valid && rdata == '0));
  p_pure_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op[1] && !src_nz && csr_addr == 12'hF11 && priv == 2'b11) |=> !illegal);
endmodule

bind csr_rmw_unit csr_rmw_unit_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_csr_rmw_unit.sv
module test_csr_rmw_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROV = 32'h0000_0A5C;

  logic clk = 0, rst_n = 0, req_valid = 0, src_nz = 0;
  logic [1:0] op = 0, priv = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] src = 0;
  logic resp_valid, illegal;
  logic [31:0] rdata;
  int total = 0, bad = 0;

  csr_rmw_unit i_csr_rmw_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] o, input logic [11:0] a, input logic [31:0] s,
                        input logic nz, input logic [1:0] p,
                        output logic [31:0] rd, output logic ill);
    @(negedge clk);
    req_valid = 1; op = o; csr_addr = a; src = s; src_nz = nz; priv = p;
    @(negedge clk);
    req_valid = 0;
    chk("R5 resp_valid", {31'b0, resp_valid}, 1);
    rd = rdata; ill = illegal;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] rd);
    logic ill;
    access(2'b10, a, 32'hFFFF_FFFF, 1'b0, 2'b11, rd, ill);
    chk("R4 read legal", {31'b0, ill}, 0);
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    @(negedge clk);
    chk("R10 resp_valid idle", {31'b0, resp_valid}, 0);
    peek(12'h040, rd); chk("R10 usr reset", rd, 0);
    peek(12'h140, rd); chk("R10 sup reset", rd, 0);
    peek(12'h340, rd); chk("R10 mch reset", rd, 0);
    peek(12'hF11, rd); chk("R10 ro reset", rd, ROV);
  endtask

  task automatic t_swap;
    logic [31:0] rd; logic ill;
    access(2'b01, 12'h040, 32'hDEAD_BEEF, 1'b1, 2'b00, rd, ill);
    chk("R1 swap legal", {31'b0, ill}, 0);
    chk("R5 swap old", rd, 0);
    access(2'b01, 12'h040, 32'h1234_5678, 1'b0, 2'b00, rd, ill);
    chk("R1 swap second old", rd, 32'hDEAD_BEEF);
    peek(12'h040, rd); chk("R1 swap stored", rd, 32'h1234_5678);
  endtask

  task automatic t_set_clear;
    logic [31:0] rd; logic ill;
    access(2'b01, 12'h140, 32'hA5A5_0000, 1'b1, 2'b01, rd, ill);
    access(2'b10, 12'h140, 32'h0000_00FF, 1'b1, 2'b01, rd, ill);
    chk("R2 set old", rd, 32'hA5A5_0000);
    peek(12'h140, rd); chk("R2 set stored", rd, 32'hA5A5_00FF);
    access(2'b11, 12'h140, 32'hFF00_000F, 1'b1, 2'b11, rd, ill);
    chk("R3 clear old", rd, 32'hA5A5_00FF);
    peek(12'h140, rd); chk("R3 clear stored", rd, 32'h00A5_00F0);
  endtask

  task automatic t_zero_field;
    logic [31:0] rd; logic ill;
    access(2'b11, 12'h140, 32'hFFFF_FFFF, 1'b0, 2'b01, rd, ill);
    chk("R4 clear nz0 ret", rd, 32'h00A5_00F0);
    peek(12'h140, rd); chk("R4 clear nz0 unchanged", rd, 32'h00A5_00F0);
    access(2'b10, 12'hF11, 32'hFFFF_FFFF, 1'b0, 2'b11, rd, ill);
    chk("R4 ro read legal", {31'b0, ill}, 0);
    chk("R4 ro read value", rd, ROV);
  endtask

  task automatic t_reject;
    logic [31:0] rd; logic ill;
    access(2'b01, 12'h340, 32'h7777_7777, 1'b1, 2'b01, rd, ill);
    chk("R7 sup->mch illegal", {31'b0, ill}, 1);
    chk("R9 rejected rdata", rd, 0);
    access(2'b10, 12'h140, 32'h1, 1'b1, 2'b00, rd, ill);
    chk("R7 usr->sup illegal", {31'b0, ill}, 1);
    peek(12'h340, rd); chk("R9 mch unchanged", rd, 0);
    peek(12'h140, rd); chk("R9 sup unchanged", rd, 32'h00A5_00F0);
    access(2'b01, 12'h123, 32'h0, 1'b1, 2'b11, rd, ill);
    chk("R6 unknown addr", {31'b0, ill}, 1);
    access(2'b00, 12'h040, 32'h0, 1'b1, 2'b11, rd, ill);
    chk("R6 null op", {31'b0, ill}, 1);
    access(2'b01, 12'hF11, 32'h0, 1'b1, 2'b11, rd, ill);
    chk("R8 ro swap illegal", {31'b0, ill}, 1);
    access(2'b11, 12'hF11, 32'h4, 1'b1, 2'b11, rd, ill);
    chk("R8 ro clear illegal", {31'b0, ill}, 1);
    access(2'b10, 12'hF11, 32'h0, 1'b1, 2'b11, rd, ill);
    chk("R8 ro zero mask legal", {31'b0, ill}, 0);
    chk("R8 ro zero mask value", rd, ROV);
    peek(12'hF11, rd); chk("R9 ro unchanged", rd, ROV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_swap;
    t_set_clear;
    t_zero_field;
    t_reject;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule